// File: doc/BRIEF.md
# Interrupt Latch and Soft-Reset Register Block

This block sits beside a serial-peripheral core and turns that core's event lines into a latched, maskable interrupt. Each event source owns one status bit. A rising edge on the source's event line sets that bit, and the bit stays set until software writes a one back to its position. A per-source enable register and one global enable bit both gate the single level-sensitive interrupt output.

The same register port also holds a soft-reset register. A write of one specific key value starts a reset pulse of fixed length to the attached core. That pulse also wipes the status register, the per-source enable register and the global enable bit. A write of any other value to that register is discarded.

Registers sit at fixed byte offsets on a simple single-cycle write port. Read data follows the address combinationally.

Top module: `irqc_top`

## Requirements
- R1: After reset, `irqOut` and `coreRst` are 0, and reads of the global-enable (0x1C), status (0x20) and source-enable (0x28) registers return 0.
- R2: The global-enable register at offset 0x1C stores only bit 31. A read returns bit 31 as written and 0 in every other bit.
- R3: The source-enable register at offset 0x28 stores bits 6..0, one bit per source. A read returns those bits with bits 31..7 at 0.
- R4: Status bit n at offset 0x20 is set on the clock edge where `evtIn[n]` is first seen high after being low, whether or not source n is enabled. The source bits are: 0 mode fault, 1 slave-mode fault, 2 transmit FIFO empty, 3 transmit underrun, 4 receive full, 5 receive overrun, 6 transmit FIFO half empty. An event line that stays high sets its bit only once.
- R5: A write to offset 0x20 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R6: When an event rises in the same cycle as a write that clears its status bit, that bit ends up set.
- R7: `irqOut` is 1 exactly when the global-enable bit is set and at least one status bit has its source-enable bit set.
- R8: A write of 0x0A to offset 0x40 raises `coreRst` on the next clock edge and holds it high for exactly PULSE_LEN (default 4) cycles.
- R9: A write to offset 0x40 of any value other than 0x0A leaves `coreRst` low and changes no register.
- R10: The reset pulse clears the status, source-enable and global-enable registers. While the pulse lasts, writes to those registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Write strobe for one cycle |
| regAddr | input | 8 | Byte offset used for both write and read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the register at `regAddr` |
| evtIn | input | 7 | Event lines from the attached core |
| irqOut | output | 1 | Level interrupt request |
| coreRst | output | 1 | Soft-reset pulse to the attached core |

## Verification
The latch is tested in three ways: with single event pulses on masked sources, with a source held high across a clear, and with an event that rises in the same cycle as a clear of its own bit. Between them these show edge capture apart from level capture, and show which side wins the clear-versus-set race.

The interrupt output is tested with each gate opened and closed on its own. This exposes a missing global gate apart from a missing per-source mask. The reset register is given near-miss values before the real key, so a loose key compare stands out. The pulse is counted cycle by cycle to catch an error of one cycle in its length.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_GATE = 2'd1,
    SEL_PEND = 2'd2,
    SEL_MASK = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrGate;
    logic   wrPend;
    logic   wrMask;
    logic   busy;
    rdSel_e rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] OFF_GATE = 8'h1C,
  parameter logic [ADDR_W-1:0] OFF_PEND = 8'h20,
  parameter logic [ADDR_W-1:0] OFF_MASK = 8'h28,
  parameter logic [ADDR_W-1:0] OFF_RST  = 8'h40,
  parameter logic [DATA_W-1:0] RST_KEY  = 32'h0000_000A,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output ctlStrobe_t        ctl,
  output logic              coreRst
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] pulseCnt;
  logic             busy;
  logic             keyHit;

  assign busy   = (pulseCnt != '0);
  assign keyHit = regWrEn && (regAddr == OFF_RST) && (regWrData == RST_KEY);

  // Pulse counter: loads on a valid key, counts down to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (busy) begin
      pulseCnt <= pulseCnt - 1'b1;
    end else if (keyHit) begin
      pulseCnt <= CNT_LOAD;
    end
  end

  assign coreRst = busy;

  always_comb begin
    ctl.wrGate = regWrEn && !busy && (regAddr == OFF_GATE);
    ctl.wrPend = regWrEn && !busy && (regAddr == OFF_PEND);
    ctl.wrMask = regWrEn && !busy && (regAddr == OFF_MASK);
    ctl.busy   = busy;
    if (regAddr == OFF_GATE)      ctl.rdSel = SEL_GATE;
    else if (regAddr == OFF_PEND) ctl.rdSel = SEL_PEND;
    else if (regAddr == OFF_MASK) ctl.rdSel = SEL_MASK;
    else                          ctl.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/irqc_dpath.sv
module irqc_dpath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC  = 7,
  parameter int DATA_W   = 32,
  parameter int GATE_BIT = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [NUM_SRC-1:0] evtIn,
  output logic               gateQ,
  output logic [NUM_SRC-1:0] pendQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] evtPrev;
  logic [NUM_SRC-1:0] evtRise;
  logic [NUM_SRC-1:0] pendNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtPrev <= '0;
    else       evtPrev <= evtIn;
  end

  assign evtRise = evtIn & ~evtPrev;

  // One latch cell per source: an arriving edge beats a clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    always_comb begin
      if (ctl.busy)                         pendNext[i] = 1'b0;
      else if (evtRise[i])                  pendNext[i] = 1'b1;
      else if (ctl.wrPend && regWrData[i])  pendNext[i] = 1'b0;
      else                                  pendNext[i] = pendQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
      gateQ <= 1'b0;
    end else begin
      pendQ <= pendNext;
      if (ctl.busy)        maskQ <= '0;
      else if (ctl.wrMask) maskQ <= regWrData[NUM_SRC-1:0];
      if (ctl.busy)        gateQ <= 1'b0;
      else if (ctl.wrGate) gateQ <= regWrData[GATE_BIT];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (ctl.rdSel)
      SEL_GATE: rdData[GATE_BIT]    = gateQ;
      SEL_PEND: rdData[NUM_SRC-1:0] = pendQ;
      SEL_MASK: rdData[NUM_SRC-1:0] = maskQ;
      default:  rdData = '0;
    endcase
  end

  assign irqOut = gateQ && |(pendQ & maskQ);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC   = 7,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int GATE_BIT  = 31,
  parameter logic [ADDR_W-1:0] OFF_GATE = 8'h1C,
  parameter logic [ADDR_W-1:0] OFF_PEND = 8'h20,
  parameter logic [ADDR_W-1:0] OFF_MASK = 8'h28,
  parameter logic [ADDR_W-1:0] OFF_RST  = 8'h40,
  parameter logic [DATA_W-1:0] RST_KEY  = 32'h0000_000A,
  parameter int PULSE_LEN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] evtIn,
  output logic               irqOut,
  output logic               coreRst
);
  ctlStrobe_t         ctl;
  logic               gateQ;
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] maskQ;

  irqc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFF_GATE(OFF_GATE), .OFF_PEND(OFF_PEND), .OFF_MASK(OFF_MASK),
    .OFF_RST(OFF_RST), .RST_KEY(RST_KEY), .PULSE_LEN(PULSE_LEN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .ctl(ctl), .coreRst(coreRst)
  );

  irqc_dpath #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .GATE_BIT(GATE_BIT)
  ) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regWrData(regWrData),
    .evtIn(evtIn), .gateQ(gateQ), .pendQ(pendQ), .maskQ(maskQ),
    .rdData(regRdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 7,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] OFF_PEND = 8'h20,
  parameter logic [ADDR_W-1:0] OFF_RST  = 8'h40,
  parameter logic [DATA_W-1:0] RST_KEY  = 32'h0000_000A
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic [NUM_SRC-1:0] evtIn,
  input logic               irqOut,
  input logic               coreRst,
  input logic               gateQ,
  input logic [NUM_SRC-1:0] pendQ,
  input logic [NUM_SRC-1:0] maskQ
);
  logic [NUM_SRC-1:0] seenPrev;
  logic [NUM_SRC-1:0] seenRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenPrev <= '0;
    else       seenPrev <= evtIn;
  end
  assign seenRise = evtIn & ~seenPrev;

  a_r8_pulse_start: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_RST && regWrData == RST_KEY && !coreRst) |=> coreRst);

  a_r9_bad_key: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_RST && regWrData != RST_KEY && !coreRst) |=> !coreRst);

  a_r10_pulse_clears: assert property (@(posedge clk) disable iff (!rstN)
    coreRst |=> (pendQ == '0 && maskQ == '0 && !gateQ));

  a_r7_gate_closed: assert property (@(posedge clk) disable iff (!rstN)
    !gateQ |-> !irqOut);

  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (!coreRst && seenRise != '0) |=> ((pendQ & $past(seenRise)) == $past(seenRise)));

  a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    (!coreRst && !(regWrEn && regAddr == OFF_PEND)) |=> ((pendQ & $past(pendQ)) == $past(pendQ)));
endmodule

bind irqc_top irqc_checker #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .OFF_PEND(OFF_PEND), .OFF_RST(OFF_RST), .RST_KEY(RST_KEY)
) chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .evtIn(evtIn), .irqOut(irqOut), .coreRst(coreRst),
  .gateQ(gateQ), .pendQ(pendQ), .maskQ(maskQ)
);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic [6:0]  evtIn = 7'h0;
  logic        irqOut;
  logic        coreRst;

  int nChecks = 0;
  int nFails  = 0;

  localparam logic [7:0] A_GATE = 8'h1C;
  localparam logic [7:0] A_PEND = 8'h20;
  localparam logic [7:0] A_MASK = 8'h28;
  localparam logic [7:0] A_RST  = 8'h40;

  always #2.5 clk = ~clk;

  irqc_top uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtIn(evtIn),
    .irqOut(irqOut), .coreRst(coreRst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 32'h0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulseEvt(input logic [6:0] m);
    @(negedge clk);
    evtIn = evtIn | m;
    @(negedge clk);
    evtIn = evtIn & ~m;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);
    check("R1 coreRst", {31'b0, coreRst}, 32'h0);
    regRead(A_GATE, v); check("R1 gate", v, 32'h0);
    regRead(A_PEND, v); check("R1 status", v, 32'h0);
    regRead(A_MASK, v); check("R1 enable", v, 32'h0);
  endtask

  task automatic testEnables();
    logic [31:0] v;
    regWrite(A_GATE, 32'hFFFF_FFFF);
    regRead(A_GATE, v); check("R2 gate only bit31", v, 32'h8000_0000);
    regWrite(A_GATE, 32'h7FFF_FFFF);
    regRead(A_GATE, v); check("R2 gate cleared", v, 32'h0);
    regWrite(A_MASK, 32'hFFFF_FFFF);
    regRead(A_MASK, v); check("R3 enable width", v, 32'h7F);
    regWrite(A_MASK, 32'h15);
    regRead(A_MASK, v); check("R3 enable pattern", v, 32'h15);
  endtask

  task automatic testLatch();
    logic [31:0] v;
    regWrite(A_MASK, 32'h0);
    regWrite(A_GATE, 32'h8000_0000);
    pulseEvt(7'h04);
    regRead(A_PEND, v); check("R4 masked latch", v, 32'h04);
    check("R7 masked no irq", {31'b0, irqOut}, 32'h0);
    @(negedge clk); evtIn[5] = 1'b1;
    regRead(A_PEND, v); check("R4 level sets", v, 32'h24);
    regWrite(A_PEND, 32'h20);
    regRead(A_PEND, v); check("R4 held level no reset", v, 32'h04);
    @(negedge clk); evtIn[5] = 1'b0;
  endtask

  task automatic testClear();
    logic [31:0] v;
    pulseEvt(7'h41);
    regRead(A_PEND, v); check("R4 two sources", v, 32'h45);
    regWrite(A_PEND, 32'h41);
    regRead(A_PEND, v); check("R5 partial clear", v, 32'h04);
  endtask

  task automatic testIrq();
    regWrite(A_MASK, 32'h04);
    #1 check("R7 asserted", {31'b0, irqOut}, 32'h1);
    regWrite(A_GATE, 32'h0);
    #1 check("R7 global gate off", {31'b0, irqOut}, 32'h0);
    regWrite(A_GATE, 32'h8000_0000);
    regWrite(A_MASK, 32'h40);
    #1 check("R7 other source only", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic testCollision();
    logic [31:0] v;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = A_PEND; regWrData = 32'h0C; evtIn[3] = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 32'h0; evtIn[3] = 1'b0;
    regRead(A_PEND, v); check("R6 event beats clear", v, 32'h08);
  endtask

  task automatic testBadKey();
    logic [31:0] v;
    logic [31:0] bad [3] = '{32'h0B, 32'h00, 32'h1A};
    for (int k = 0; k < 3; k++) begin
      regWrite(A_RST, bad[k]);
      check("R9 no pulse", {31'b0, coreRst}, 32'h0);
      @(negedge clk);
      check("R9 no pulse later", {31'b0, coreRst}, 32'h0);
    end
    regRead(A_PEND, v); check("R9 status kept", v, 32'h08);
    regRead(A_MASK, v); check("R9 enable kept", v, 32'h40);
    regRead(A_GATE, v); check("R9 gate kept", v, 32'h8000_0000);
  endtask

  task automatic testKey();
    logic [31:0] v;
    regWrite(A_MASK, 32'h08);
    #1 check("R7 before pulse", {31'b0, irqOut}, 32'h1);
    regWrite(A_RST, 32'h0A);
    check("R8 pulse cycle 0", {31'b0, coreRst}, 32'h1);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      check("R8 pulse held", {31'b0, coreRst}, 32'h1);
    end
    @(negedge clk);
    check("R8 pulse ended", {31'b0, coreRst}, 32'h0);
    check("R10 irq dropped", {31'b0, irqOut}, 32'h0);
    regRead(A_PEND, v); check("R10 status cleared", v, 32'h0);
    regRead(A_MASK, v); check("R10 enable cleared", v, 32'h0);
    regRead(A_GATE, v); check("R10 gate cleared", v, 32'h0);
  endtask

  task automatic testWriteDuringPulse();
    logic [31:0] v;
    regWrite(A_RST, 32'h0A);
    regWrite(A_MASK, 32'h7F);
    repeat (4) @(negedge clk);
    check("R10 pulse over", {31'b0, coreRst}, 32'h0);
    regRead(A_MASK, v); check("R10 write ignored in pulse", v, 32'h0);
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEnables();
    testLatch();
    testClear();
    testIrq();
    testCollision();
    testBadKey();
    testKey();
    testWriteDuringPulse();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule